// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Sync Generator

This block divides the system clock down to a serial bit clock and, counting periods of that bit clock, emits a periodic frame-sync pulse. The frame period and the pulse width are both programmable. It also gives a one-cycle strobe on every bit-clock rising edge. Downstream shift logic can therefore stay on the system clock and advance on the strobe, without using the divided clock as a clock.

Two enables act as resets. The clock enable releases the divider. The frame enable releases the frame-sync stage, and it is meant to rise only after the divider has run for a couple of bit-clock periods. The divide value, frame period and pulse width are all written as value-plus-one. They are taken into working registers only at safe points, so a reprogramming never produces a shortened bit clock or a runt sync pulse.

Top module: `sfg_top`

## Requirements
- R1: While rst_ni is low, and in every cycle after clk_en_i is sampled low, sclk_o, sclk_rise_o and fsync_o are all 0.
- R2: In the first cycle after clk_en_i is sampled high, sclk_rise_o is 1. It then pulses for one cycle every N = div_i+1 system cycles, and is 0 in the cycles between.
- R3: For N of 2 or more, sclk_o is high for floor(N/2) cycles starting at the strobe cycle and is low for the rest of the period. For N = 1, sclk_o stays high.
- R4: With the frame stage running, a frame lasts P = per_i+1 bit-clock periods. Each frame begins on a strobe cycle.
- R5: fsync_o is high for the first wid_i+1 bit-clock periods of each frame. If wid_i is at least per_i, it stays high continuously.
- R6: After fs_en_i is sampled low, fsync_o is 0 from the next cycle on and the frame count restarts. Once fs_en_i is high, the first pulse starts on the first strobe that comes strictly after the first cycle in which fs_en_i is sampled high while the divider runs.
- R7: A change to div_i, per_i or wid_i takes effect at the next frame boundary while the frame stage runs. With the frame stage off, it takes effect at the end of the current bit-clock period. With the divider off, it takes effect at once.
- R8: fsync_o changes level only in a strobe cycle, except when it drops because an enable was removed.
- R9: fs_en_i has no effect while the divider is held off: fsync_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Releases the bit-clock divider when high |
| fs_en_i | input | 1 | Releases the frame-sync stage when high |
| div_i | input | DIV_W | Divide value; ratio is div_i+1 |
| per_i | input | FRM_W | Frame period in bit-clock periods, minus one |
| wid_i | input | FRM_W | Sync pulse width in bit-clock periods, minus one |
| sclk_o | output | 1 | Divided bit clock |
| sclk_rise_o | output | 1 | One-cycle strobe at each bit-clock rising edge |
| fsync_o | output | 1 | Frame-sync pulse |

## Verification
The assertions assume that the frame enable is raised only after the clock enable. They also assume that the configuration inputs may change at any cycle, but that only the latched copies steer the counters. The stimulus respects this. Every sweep run first drops both enables, loads a configuration, releases the divider, and only two or more bit-clock periods later releases the frame stage. Reprogramming in mid-frame is exercised once, on a running frame, so that the deferred update is observed at its boundary.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_RUN  = 1'b1
  } fs_state_e;
endpackage

// File: rtl/sfg_cfg_latch.sv
module sfg_cfg_latch #(
  parameter int DIV_W = 8,
  parameter int FRM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [FRM_W-1:0] per_i,
  input  logic [FRM_W-1:0] wid_i,
  output logic [DIV_W-1:0] div_o,
  output logic [FRM_W-1:0] per_o,
  output logic [FRM_W-1:0] wid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o <= '0;
      per_o <= '0;
      wid_o <= '0;
    end else if (load_i) begin
      div_o <= div_i;
      per_o <= per_i;
      wid_o <= wid_i;
    end
  end
endmodule

// File: rtl/sfg_clk_div.sv
module sfg_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             run_o,
  output logic             last_o,
  output logic             sclk_o,
  output logic             rise_o
);
  localparam int HW = DIV_W + 1;

  logic             run_q;
  logic [DIV_W-1:0] cnt_q;
  logic [HW-1:0]    ratio;
  logic [HW-1:0]    half;

  // high phase is floor(ratio/2): the shorter phase for odd ratios
  assign ratio = {1'b0, div_i} + {{DIV_W{1'b0}}, 1'b1};
  assign half  = ratio >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= en_i;
      if (!run_q || cnt_q == div_i) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o  = run_q;
  assign last_o = run_q && (cnt_q == div_i);
  assign rise_o = run_q && (cnt_q == '0);
  assign sclk_o = run_q && ((div_i == '0) || ({1'b0, cnt_q} < half));

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_i);
endmodule

// File: rtl/sfg_frame_gen.sv
module sfg_frame_gen
  import sfg_pkg::*;
#(
  parameter int FRM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             en_i,
  input  logic             last_i,
  input  logic [FRM_W-1:0] per_i,
  input  logic [FRM_W-1:0] wid_i,
  output logic             bnd_o,
  output logic             fsync_o
);
  fs_state_e        st_q;
  logic [FRM_W-1:0] fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      fcnt_q <= '0;
    end else if (!run_i || !en_i) begin
      st_q   <= FS_IDLE;
      fcnt_q <= '0;
    end else if (last_i) begin
      if (st_q == FS_IDLE) begin
        st_q   <= FS_RUN;
        fcnt_q <= '0;
      end else if (fcnt_q == per_i) begin
        fcnt_q <= '0;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  // frame boundary: end of last bit-clock period of a frame, or any period while idle
  assign bnd_o   = last_i && ((st_q == FS_IDLE) || (fcnt_q == per_i));
  assign fsync_o = run_i && (st_q == FS_RUN) && (fcnt_q <= wid_i);

  assert_fcnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcnt_q <= per_i);
  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FS_IDLE) |-> (fcnt_q == '0));
endmodule

// File: rtl/sfg_top.sv
module sfg_top #(
  parameter int DIV_W = 8,
  parameter int FRM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             fs_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [FRM_W-1:0] per_i,
  input  logic [FRM_W-1:0] wid_i,
  output logic             sclk_o,
  output logic             sclk_rise_o,
  output logic             fsync_o
);
  logic             run_w;
  logic             last_w;
  logic             bnd_w;
  logic             load_w;
  logic [DIV_W-1:0] div_q;
  logic [FRM_W-1:0] per_q;
  logic [FRM_W-1:0] wid_q;

  assign load_w = !run_w || bnd_w;

  sfg_cfg_latch #(.DIV_W(DIV_W), .FRM_W(FRM_W)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .div_i  (div_i),
    .per_i  (per_i),
    .wid_i  (wid_i),
    .div_o  (div_q),
    .per_o  (per_q),
    .wid_o  (wid_q)
  );

  sfg_clk_div #(.DIV_W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en_i),
    .div_i  (div_q),
    .run_o  (run_w),
    .last_o (last_w),
    .sclk_o (sclk_o),
    .rise_o (sclk_rise_o)
  );

  sfg_frame_gen #(.FRM_W(FRM_W)) i_frm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_w),
    .en_i    (fs_en_i),
    .last_i  (last_w),
    .per_i   (per_q),
    .wid_i   (wid_q),
    .bnd_o   (bnd_w),
    .fsync_o (fsync_o)
  );

  assert_idle_outputs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> (!sclk_o && !sclk_rise_o && !fsync_o));
  assert_rise_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise_o |-> sclk_o);
  assert_fs_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_en_i |=> !fsync_o);
  assert_fs_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fsync_o) |-> sclk_rise_o);
  assert_fs_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fsync_o) |-> (sclk_rise_o || !$past(fs_en_i) || !$past(clk_en_i)));
  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && !bnd_w) |=> $stable(per_q) && $stable(wid_q) && $stable(div_q));
endmodule

// File: tb/test_sfg_top.sv
`timescale 1ns/1ps
module test_sfg_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clk_en_i = 1'b0;
  logic       fs_en_i = 1'b0;
  logic [7:0] div_i = '0;
  logic [7:0] per_i = '0;
  logic [7:0] wid_i = '0;
  logic       sclk_o, sclk_rise_o, fsync_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sfg_top i_sfg_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i), .fs_en_i(fs_en_i),
    .div_i(div_i), .per_i(per_i), .wid_i(wid_i),
    .sclk_o(sclk_o), .sclk_rise_o(sclk_rise_o), .fsync_o(fsync_o)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic exp_sclk(int k, int n);
    return (n == 1) ? 1'b1 : ((k % n) < (n / 2));
  endfunction

  function automatic logic exp_fs(int k, int s, int n, int p, int w);
    if (k < s) return 1'b0;
    return (((k - s) / n) % p) <= w;
  endfunction

  task automatic run_cfg(input int dv, input int pr, input int wd);
    int n, p, k0, s, kend;
    n = dv + 1; p = pr + 1;
    @(negedge clk_i);
    clk_en_i = 0; fs_en_i = 0;
    div_i = 8'(dv); per_i = 8'(pr); wid_i = 8'(wd);
    @(negedge clk_i);
    chk(sclk_o, 1'b0, "R1 sclk idle");
    chk(sclk_rise_o, 1'b0, "R1 rise idle");
    chk(fsync_o, 1'b0, "R1 fsync idle");
    fs_en_i = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(fsync_o, 1'b0, "R9 fs_en without divider");
    end
    fs_en_i = 0;
    clk_en_i = 1;
    k0 = 2 * n + n / 2;
    s = (k0 / n + 1) * n;
    kend = s + 2 * n * p + n;
    for (int k = 0; k <= kend; k++) begin
      @(negedge clk_i);
      chk(sclk_rise_o, ((k % n) == 0), "R2 strobe");
      chk(sclk_o, exp_sclk(k, n), "R3 sclk");
      chk(fsync_o, exp_fs(k, s, n, p, wd), "R4 R5 R6 fsync");
      if (k == k0) fs_en_i = 1;
    end
  endtask

  initial begin
    #1;
    chk(sclk_o, 1'b0, "R1 reset sclk");
    chk(sclk_rise_o, 1'b0, "R1 reset rise");
    chk(fsync_o, 1'b0, "R1 reset fsync");
    repeat (3) @(negedge clk_i);
    chk(fsync_o, 1'b0, "R1 reset fsync held");
    rst_ni = 1;

    for (int dv = 0; dv < 4; dv++)
      for (int pr = 1; pr < 5; pr++)
        for (int wd = 0; wd <= pr; wd++)
          run_cfg(dv, pr, wd);

    // R7: mid-frame reprogramming
    begin
      int s, fb, kend;
      @(negedge clk_i);
      clk_en_i = 0; fs_en_i = 0;
      div_i = 8'd1; per_i = 8'd3; wid_i = 8'd1;
      @(negedge clk_i);
      clk_en_i = 1;
      @(negedge clk_i);          // phase 0
      chk(sclk_rise_o, 1'b1, "R2 first strobe");
      fs_en_i = 1;               // sampled at phase 0 -> s = 2
      s = 2; fb = s + 8; kend = fb + 2 * 3 * 3 + 1;
      for (int k = 1; k <= kend; k++) begin
        @(negedge clk_i);
        if (k < fb) begin
          chk(sclk_rise_o, ((k % 2) == 0), "R7 old strobe");
          chk(sclk_o, exp_sclk(k, 2), "R7 old sclk");
          chk(fsync_o, exp_fs(k, s, 2, 4, 1), "R7 old fsync");
        end else begin
          chk(sclk_rise_o, (((k - fb) % 3) == 0), "R7 new strobe");
          chk(sclk_o, exp_sclk(k - fb, 3), "R7 new sclk");
          chk(fsync_o, exp_fs(k - fb, 0, 3, 3, 0), "R7 new fsync");
        end
        if (k == s + 3) begin
          div_i = 8'd2; per_i = 8'd2; wid_i = 8'd0;
        end
      end
      // R6: frame enable dropped mid-run
      fs_en_i = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk_i);
        chk(fsync_o, 1'b0, "R6 fsync off after disable");
      end
      // R1: divider disabled, all outputs low next cycle
      clk_en_i = 0;
      @(negedge clk_i);
      chk(sclk_o, 1'b0, "R1 sclk off");
      chk(sclk_rise_o, 1'b0, "R1 rise off");
      chk(fsync_o, 1'b0, "R1 fsync off");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule